// File: doc/BRIEF.md
# Register Command Interpreter

This block takes a stream of 32-bit command words on a write port and turns them into operations on a bank of 32 registers of 32 bits each. The bank sits outside the block and is reached through one shared address with a write enable and a read-data return. The supported operations are:

- a multi-register load steered by a selector mask;
- a single-register AND, OR or XOR;
- a streamed read-back, where each read of the output register returns the next selected register.

The block also starts and stops frames for the datapath. It tracks whether a frame is running. If a frame start arrives while a frame is already running, the command channel locks.

A command begins with a word whose top byte is the operation code. Words that follow are taken as arguments until the command is complete, so an argument's top byte is never decoded. The datapath reports the end of a frame on `frame_done`. A stop command is always honoured, even when the channel is locked.

Top module: `cmd_interp`

## Requirements
- R1: A word is decoded as a command only when no command is in progress. Its bits 31:24 select the operation: 0x01 load, 0x02 AND, 0x03 OR, 0x04 XOR, 0x05 read, 0x06 frame start, 0x07 stop. Any other code is ignored, and the next word is again decoded as a command.
- R2: After a load code, the next word is a selector. Each following word is written to the lowest selector bit not yet served, in ascending bit order. The write appears on `reg_we`/`reg_addr`/`reg_wdata` in the same cycle the word is presented.
- R3: A load selector of zero ends the load at once, and the next word is decoded as a command.
- R4: An AND, OR or XOR command names a register in bits 4:0 and is followed by one value word. In that word's cycle, the register is rewritten with its current contents combined with the value. No other register is written.
- R5: After a read code, the next word is a selector. `out_data` then shows the selected registers one by one in ascending bit order, and each one-cycle `out_rd` advances to the next. Each value is ready two cycles after the selector is accepted or after the advancing read. `out_data` is zero when nothing is pending.
- R6: A selected register whose bit in `READ_MASK` is clear is returned as zero. By default only register 7 is unreadable.
- R7: A frame start while no frame is running gives a one-cycle `frame_start` in the next cycle. `frame_busy` is then held until `frame_done`.
- R8: Load, bitwise and read commands are carried out normally while `frame_busy` is high.
- R9: A frame start while `frame_busy` is high gives no `frame_start` and sets `cmd_locked`. While locked, every command word except stop is discarded.
- R10: A stop command gives a one-cycle `frame_stop` in the next cycle. It clears `frame_busy` and `cmd_locked` and writes no register. It is accepted even when locked.
- R11: After reset, no frame is busy, the channel is unlocked, `out_data` is zero, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word strobe |
| cmd_data | input | 32 | Command or argument word |
| out_rd | input | 1 | Output register read strobe |
| out_data | output | 32 | Output register value |
| reg_we | output | 1 | Register bank write enable |
| reg_addr | output | 5 | Register bank address, shared by write and read |
| reg_wdata | output | 32 | Register bank write data |
| reg_rdata | input | 32 | Register bank read data at `reg_addr`, combinational |
| frame_done | input | 1 | Datapath reports end of frame |
| frame_start | output | 1 | One-cycle frame start pulse |
| frame_stop | output | 1 | One-cycle frame abandon pulse |
| frame_busy | output | 1 | A frame is in progress |
| cmd_locked | output | 1 | Command channel is locked |

## Verification
A wrong parser state causes a misaligned command stream. An argument would be taken as a command, or a command as an argument. This shows up at the bank port in the very cycle of the next word, as a write to the wrong register or a missing write. A wrong read pointer or mask shows up two cycles after an `out_rd`, as a value out of order or a non-zero word for an unreadable register. Lock and busy errors appear one cycle after the frame or stop word, on the pulse outputs, and afterwards as load writes that should have been dropped, or dropped writes that should have happened.

// File: rtl/cmd_interp_pkg.sv
package cmd_interp_pkg;

    localparam int CI_DW   = 32;
    localparam int CI_NREG = 32;
    localparam int CI_AW   = $clog2(CI_NREG);

    localparam logic [7:0] OPC_LOAD  = 8'h01;
    localparam logic [7:0] OPC_AND   = 8'h02;
    localparam logic [7:0] OPC_OR    = 8'h03;
    localparam logic [7:0] OPC_XOR   = 8'h04;
    localparam logic [7:0] OPC_READ  = 8'h05;
    localparam logic [7:0] OPC_FRAME = 8'h06;
    localparam logic [7:0] OPC_STOP  = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_SEL,
        ST_LD_ARG,
        ST_BW_VAL,
        ST_RD_SEL
    } parse_st_e;

    typedef enum logic [1:0] {
        BW_AND,
        BW_OR,
        BW_XOR
    } bw_op_e;

    typedef struct packed {
        parse_st_e          state;
        logic [CI_NREG-1:0] ld_mask;
        logic [CI_AW-1:0]   bw_reg;
        bw_op_e             bw_op;
        logic [CI_NREG-1:0] rd_mask;
        logic [CI_DW-1:0]   out_val;
        logic               out_vld;
    } core_s;

    typedef struct packed {
        logic busy;
        logic lock;
        logic start;
        logic stop;
    } frm_s;

endpackage

// File: rtl/cmd_sel_scan.sv
module cmd_sel_scan #(
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [AW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = AW'(i);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        if (any) begin
            AST_SCAN_HIT: assert (mask[idx]); // R2
        end
    end

endmodule

// File: rtl/cmd_frame_ctl.sv
module cmd_frame_ctl
    import cmd_interp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic halt,
    input  logic done,
    output logic start_o,
    output logic stop_o,
    output logic busy_o,
    output logic lock_o
);

    frm_s f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.start = 1'b0;
        f_d.stop  = 1'b0;
        if (done) begin
            f_d.busy = 1'b0;
        end
        if (halt) begin
            f_d.busy = 1'b0;
            f_d.lock = 1'b0;
            f_d.stop = 1'b1;
        end else if (go && !f_q.lock) begin
            if (f_q.busy) begin
                f_d.lock = 1'b1;
            end else begin
                f_d.start = 1'b1;
                f_d.busy  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign start_o = f_q.start;
    assign stop_o  = f_q.stop;
    assign busy_o  = f_q.busy;
    assign lock_o  = f_q.lock;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.lock && !halt) |=> f_q.lock); // R9
    AST_LOCK_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.lock) |-> $past(f_q.busy)); // R9
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.stop |-> (!f_q.busy && !f_q.lock)); // R10
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({f_q.start, f_q.stop})); // R7
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.start |-> f_q.busy); // R7

endmodule

// File: rtl/cmd_interp.sv
module cmd_interp
    import cmd_interp_pkg::*;
#(
    parameter logic [CI_NREG-1:0] READ_MASK = 32'hFFFF_FF7F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [CI_DW-1:0]    cmd_data,
    input  logic                out_rd,
    output logic [CI_DW-1:0]    out_data,
    output logic                reg_we,
    output logic [CI_AW-1:0]    reg_addr,
    output logic [CI_DW-1:0]    reg_wdata,
    input  logic [CI_DW-1:0]    reg_rdata,
    input  logic                frame_done,
    output logic                frame_start,
    output logic                frame_stop,
    output logic                frame_busy,
    output logic                cmd_locked
);

    core_s c_d, c_q;

    logic [CI_AW-1:0] ld_idx, rd_idx;
    logic             ld_any, rd_any;
    logic             go, halt, rd_reload;
    logic [7:0]       opc;

    assign opc = cmd_data[CI_DW-1 -: 8];

    cmd_sel_scan #(.N(CI_NREG)) u_ld_scan (
        .mask (c_q.ld_mask),
        .idx  (ld_idx),
        .any  (ld_any)
    );

    cmd_sel_scan #(.N(CI_NREG)) u_rd_scan (
        .mask (c_q.rd_mask),
        .idx  (rd_idx),
        .any  (rd_any)
    );

    cmd_frame_ctl u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .halt    (halt),
        .done    (frame_done),
        .start_o (frame_start),
        .stop_o  (frame_stop),
        .busy_o  (frame_busy),
        .lock_o  (cmd_locked)
    );

    always_comb begin
        c_d       = c_q;
        reg_we    = 1'b0;
        reg_addr  = rd_idx;
        reg_wdata = '0;
        go        = 1'b0;
        halt      = 1'b0;
        rd_reload = 1'b0;

        if (out_rd && c_q.out_vld) begin
            c_d.out_vld = 1'b0;
        end

        if (cmd_wr) begin
            case (c_q.state)
                ST_IDLE: begin
                    if (opc == OPC_STOP) begin
                        halt = 1'b1;
                    end else if (!cmd_locked) begin
                        case (opc)
                            OPC_LOAD: c_d.state = ST_LD_SEL;
                            OPC_AND: begin
                                c_d.bw_op  = BW_AND;
                                c_d.bw_reg = cmd_data[CI_AW-1:0];
                                c_d.state  = ST_BW_VAL;
                            end
                            OPC_OR: begin
                                c_d.bw_op  = BW_OR;
                                c_d.bw_reg = cmd_data[CI_AW-1:0];
                                c_d.state  = ST_BW_VAL;
                            end
                            OPC_XOR: begin
                                c_d.bw_op  = BW_XOR;
                                c_d.bw_reg = cmd_data[CI_AW-1:0];
                                c_d.state  = ST_BW_VAL;
                            end
                            OPC_READ:  c_d.state = ST_RD_SEL;
                            OPC_FRAME: go = 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_LD_SEL: begin
                    c_d.ld_mask = cmd_data;
                    c_d.state   = (|cmd_data) ? ST_LD_ARG : ST_IDLE;
                end
                ST_LD_ARG: begin
                    reg_we              = 1'b1;
                    reg_addr            = ld_idx;
                    reg_wdata           = cmd_data;
                    c_d.ld_mask[ld_idx] = 1'b0;
                    if (c_d.ld_mask == '0) begin
                        c_d.state = ST_IDLE;
                    end
                end
                ST_BW_VAL: begin
                    reg_we   = 1'b1;
                    reg_addr = c_q.bw_reg;
                    case (c_q.bw_op)
                        BW_AND:  reg_wdata = reg_rdata & cmd_data;
                        BW_OR:   reg_wdata = reg_rdata | cmd_data;
                        default: reg_wdata = reg_rdata ^ cmd_data;
                    endcase
                    c_d.state = ST_IDLE;
                end
                ST_RD_SEL: begin
                    rd_reload   = 1'b1;
                    c_d.rd_mask = cmd_data;
                    c_d.out_vld = 1'b0;
                    c_d.out_val = '0;
                    c_d.state   = ST_IDLE;
                end
                default: c_d.state = ST_IDLE;
            endcase
        end

        if (!reg_we && !rd_reload && !c_q.out_vld && rd_any) begin
            reg_addr            = rd_idx;
            c_d.out_val         = READ_MASK[rd_idx] ? reg_rdata : '0;
            c_d.out_vld         = 1'b1;
            c_d.rd_mask[rd_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
            c_q.bw_op <= BW_AND;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_data = c_q.out_vld ? c_q.out_val : '0;

    AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !cmd_locked); // R9
    AST_NO_WRITE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stop |-> !$past(reg_we)); // R10
    AST_ARG_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_LD_ARG) |-> ld_any); // R3
    AST_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(c_q.out_vld) && !$past(rd_reload)) |-> $past(out_rd)); // R5
    AST_WRITE_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> cmd_wr); // R2

endmodule

// File: tb/cmd_interp_test.sv
module cmd_interp_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        out_rd = 1'b0;
    logic [31:0] out_data;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        frame_done = 1'b0;
    logic        frame_start, frame_stop, frame_busy, cmd_locked;

    logic [31:0] bank [32];
    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_interp uut (
        .clk (clk), .rst_n (rst_n), .cmd_wr (cmd_wr), .cmd_data (cmd_data),
        .out_rd (out_rd), .out_data (out_data), .reg_we (reg_we),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .frame_done (frame_done), .frame_start (frame_start),
        .frame_stop (frame_stop), .frame_busy (frame_busy),
        .cmd_locked (cmd_locked)
    );

    assign reg_rdata = bank[reg_addr];

    always_ff @(posedge clk) begin
        if (reg_we) bank[reg_addr] <= reg_wdata;
    end

    // cmd word, value word, register, expected result (regs 0..3 preloaded)
    localparam logic [31:0] VEC [6][4] = '{
        '{32'h0200_0000, 32'hFF00_FF00, 32'd0, 32'hF000_F000},
        '{32'h0300_0001, 32'h0F00_0000, 32'd1, 32'h1F34_5678},
        '{32'h0400_0002, 32'hFFFF_FFFF, 32'd2, 32'h0000_FFFF},
        '{32'h0300_0003, 32'hA5A5_A5A5, 32'd3, 32'hA5A5_A5A5},
        '{32'h0400_0003, 32'hFFFF_0000, 32'd3, 32'h5A5A_A5A5},
        '{32'h0200_0001, 32'h00FF_FFFF, 32'd1, 32'h0034_5678}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_data = w;
        @(negedge clk);
        cmd_wr   = 1'b0;
        cmd_data = '0;
    endtask

    task automatic pop();
        @(negedge clk);
        out_rd = 1'b1;
        @(negedge clk);
        out_rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] exp4 [4];
        for (int i = 0; i < 32; i++) bank[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 out_data", out_data, 32'h0);
        chk("R11 busy", {31'b0, frame_busy}, 32'h0);
        chk("R11 locked", {31'b0, cmd_locked}, 32'h0);
        chk("R11 pulses", {30'b0, frame_start, frame_stop}, 32'h0);

        // R2 preload regs 0..3
        cmd(32'h0100_0000); cmd(32'h0000_000F);
        cmd(32'hF0F0_F0F0); cmd(32'h1234_5678); cmd(32'hFFFF_0000); cmd(32'h0000_0000);
        chk("R2 preload r0", bank[0], 32'hF0F0_F0F0);
        chk("R2 preload r1", bank[1], 32'h1234_5678);
        exp4[0] = 32'hF0F0_F0F0; exp4[1] = 32'h1234_5678;
        exp4[2] = 32'hFFFF_0000; exp4[3] = 32'h0;

        // R4 table of bitwise operations
        for (int v = 0; v < 6; v++) begin
            cmd(VEC[v][0]);
            cmd(VEC[v][1]);
            exp4[VEC[v][2]] = VEC[v][3];
            for (int r = 0; r < 4; r++) chk("R4 bitwise", bank[r], exp4[r]);
        end

        // R2 sparse load, ascending bit order
        cmd(32'h0100_0000); cmd(32'h8000_0084);
        cmd(32'h0000_0011); cmd(32'h0000_DEAD); cmd(32'h0000_0033);
        chk("R2 sparse r2", bank[2], 32'h0000_0011);
        chk("R2 sparse r7", bank[7], 32'h0000_DEAD);
        chk("R2 sparse r31", bank[31], 32'h0000_0033);

        // R3 zero selector, then the next word is a command
        cmd(32'h0100_0000); cmd(32'h0000_0000);
        cmd(32'h0300_0004); cmd(32'h0000_0440);
        chk("R3 zero sel", bank[4], 32'h0000_0440);

        // R1 unknown opcode ignored
        cmd(32'h0900_0005);
        cmd(32'h0300_0005); cmd(32'h0000_0055);
        chk("R1 unknown op", bank[5], 32'h0000_0055);

        // R5 / R6 streamed read of regs 0, 2, 7
        cmd(32'h0500_0000); cmd(32'h0000_0085);
        repeat (2) @(negedge clk);
        chk("R5 read first", out_data, 32'hF000_F000);
        pop();
        chk("R5 read second", out_data, 32'h0000_0011);
        pop();
        chk("R6 unreadable", out_data, 32'h0);
        pop();
        chk("R5 read empty", out_data, 32'h0);

        // R7 frame start
        cmd(32'h0600_0000);
        chk("R7 start pulse", {31'b0, frame_start}, 32'h1);
        chk("R7 busy", {31'b0, frame_busy}, 32'h1);
        @(negedge clk);
        chk("R7 pulse width", {31'b0, frame_start}, 32'h0);

        // R8 setup while busy
        cmd(32'h0100_0000); cmd(32'h0000_0200); cmd(32'h0000_0099);
        chk("R8 load during frame", bank[9], 32'h0000_0099);

        // R9 lock
        cmd(32'h0600_0000);
        chk("R9 no start", {31'b0, frame_start}, 32'h0);
        chk("R9 locked", {31'b0, cmd_locked}, 32'h1);
        cmd(32'h0100_0000); cmd(32'h0000_0400); cmd(32'h0000_00AA);
        chk("R9 load dropped", bank[10], 32'h0);
        cmd(32'h0600_0000);
        chk("R9 start dropped", {31'b0, frame_start}, 32'h0);

        // R10 stop
        cmd(32'h0700_0000);
        chk("R10 stop pulse", {31'b0, frame_stop}, 32'h1);
        chk("R10 unlocked", {31'b0, cmd_locked}, 32'h0);
        chk("R10 not busy", {31'b0, frame_busy}, 32'h0);
        chk("R10 regs kept", bank[0], 32'hF000_F000);

        // R7 frame_done ends frame, next start is clean
        cmd(32'h0600_0000);
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R7 done clears busy", {31'b0, frame_busy}, 32'h0);
        cmd(32'h0600_0000);
        chk("R7 restart pulse", {31'b0, frame_start}, 32'h1);
        chk("R7 restart no lock", {31'b0, cmd_locked}, 32'h0);

        finish_run();
    end

endmodule